// File: doc/BRIEF.md
# Debounced Overcurrent Fault Latch

This block is the digital part of an overcurrent protection path. A comparator outside the block raises a single flag whenever the magnitude of the differential sense voltage is above its trip level. The block requires that flag to stay high for a qualification window before it trips. Once tripped it pulls an active-low open-drain fault pin and tells the PWM pad driver to let go of the shared PWM line, so that the pull-up can take that line high.

A trip is held until something outside the block holds the PWM line low for a minimum hold window. Only lows seen while the block's own PWM driver is off count toward that window. When the hold completes, the block waits for the next edge of the SYNC clock, in either direction. If the comparator flag is still high at that edge, the block trips again at once without a new qualification window. Otherwise it returns to watching the flag.

Wiring the fault pin to the PWM pin therefore gives an automatic reset loop. The trip pulls the line low, the hold clears the trip, and a fault that persists trips again on the following SYNC edge. Both windows are cycle counts of the block clock, nominally 50 MHz, so the default qualification time is 3.5 µs.

Top module: `oc_fault_latch`

## Requirements
- R1: A synchronous reset (`rst` = 1 at a clock edge) leaves `fault_pull` = 0, `pwm_release` = 0 and both run counters at zero, so a later trip needs a full qualification window.
- R2: While armed, `fault_pull` becomes 1 right after the edge at which `oc_flag` has been sampled 1 on DEBOUNCE_CYC consecutive edges. A single 0 sample restarts the count.
- R3: Once set, `fault_pull` stays 1 whatever `oc_flag` does, until the clear of R5 or a reset.
- R4: While the fault is set, `pwm_release` = 1 and `pwm_pull` = 0, whatever the value of `pwm_drive_low`.
- R5: A set fault clears right after the edge at which `pwm_line_in` has been sampled 0 on RESET_CYC consecutive edges with `pwm_pull` = 0. A 1 sample restarts the count.
- R6: After a clear, no qualification counting happens until the next edge of `sync_in`, meaning a sample that differs from the previous one. At that edge the fault sets again if `oc_flag` = 1, and the block returns to armed otherwise.
- R7: While the fault is not set, `pwm_pull` equals `pwm_drive_low` and `pwm_release` = 0.
- R8: With the pins tied (`pwm_line_in` = NOT(`fault_pull` OR `pwm_pull`)) and `oc_flag` held at 1, each trip lasts exactly RESET_CYC cycles, and the next SYNC edge trips the block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (nominally 50 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| oc_flag | input | 1 | Comparator flag, 1 when the magnitude of the sense input is above the threshold |
| sync_in | input | 1 | SYNC clock level, sampled by the block clock |
| pwm_line_in | input | 1 | Sensed level of the shared PWM line |
| pwm_drive_low | input | 1 | PWM generator request to pull the line low |
| fault_pull | output | 1 | Pull-down enable for the open-drain fault pin (1 = pin low) |
| pwm_release | output | 1 | 1 while the PWM pad driver is forced off |
| pwm_pull | output | 1 | Pull-down enable for the open-drain PWM pin |

## Verification
The hardest state to reach is the wait for a SYNC edge after a clear while the flag is still high. Reaching it needs a full qualification window, then a full external hold, with the SYNC level frozen the whole time so that no edge ends the wait early. Directed steps build this sequence with SYNC held constant for several qualification windows, and then toggle it once to confirm the immediate re-trip. The tied-pin loop is then run to measure each trip length. Randomized runs follow, with flag, line, SYNC, tie mode and reset all varied, and every cycle is compared with a bench model.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_TRIPPED = 2'd1,
    ST_REARM   = 2'd2
  } ocl_state_e;

  localparam int EDGE_ANY     = 0;
  localparam int EDGE_RISING  = 1;
  localparam int EDGE_FALLING = 2;

  // Next value of a run counter that holds at its last value.
  function automatic int unsigned run_next(input int unsigned cnt,
                                           input logic cond,
                                           input int unsigned last);
    if (!cond) return 0;
    if (cnt >= last) return last;
    return cnt + 1;
  endfunction

  // The run completes when the condition holds at the last counted position.
  function automatic logic run_done(input int unsigned cnt,
                                    input logic cond,
                                    input int unsigned last);
    return cond && (cnt >= last);
  endfunction

endpackage

// File: rtl/ocl_run_counter.sv
module ocl_run_counter #(
  parameter int LIMIT = 175
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic hit
);
  import ocl_pkg::*;

  localparam int          W    = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam int unsigned LAST = (LIMIT > 0) ? LIMIT - 1 : 0;

  logic [W-1:0] cnt_q;
  int unsigned  cnt_next;

  always_comb begin
    cnt_next = run_next(int'(cnt_q), cond, LAST);
    hit      = run_done(int'(cnt_q), cond, LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= W'(cnt_next);
  end

endmodule

// File: rtl/ocl_edge_detect.sv
module ocl_edge_detect #(
  parameter int MODE = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic edge_seen
);
  import ocl_pkg::*;

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  generate
    if (MODE == EDGE_RISING) begin : g_rise
      assign edge_seen = level && !level_q;
    end else if (MODE == EDGE_FALLING) begin : g_fall
      assign edge_seen = !level && level_q;
    end else begin : g_any
      assign edge_seen = level ^ level_q;
    end
  endgenerate

endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int DEBOUNCE_CYC = 175,
  parameter int RESET_CYC    = 25,
  parameter int SYNC_EDGE    = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_flag,
  input  logic sync_in,
  input  logic pwm_line_in,
  input  logic pwm_drive_low,
  output logic fault_pull,
  output logic pwm_release,
  output logic pwm_pull
);
  import ocl_pkg::*;

  ocl_state_e state_q, state_d;

  // Named internal events, also used by the bound checker.
  logic deb_cond, deb_hit;
  logic clr_cond, clr_hit;
  logic sync_edge;
  logic rearm_pending;
  logic tripped;

  assign tripped       = (state_q == ST_TRIPPED);
  assign rearm_pending = (state_q == ST_REARM);

  // Qualification only runs while armed.
  assign deb_cond = (state_q == ST_ARMED) && oc_flag;
  // A low counts only when this block is not the one pulling the line.
  assign clr_cond = tripped && !pwm_line_in && !pwm_pull;

  ocl_run_counter #(.LIMIT(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst(rst), .cond(deb_cond), .hit(deb_hit)
  );

  ocl_run_counter #(.LIMIT(RESET_CYC)) u_clr (
    .clk(clk), .rst(rst), .cond(clr_cond), .hit(clr_hit)
  );

  ocl_edge_detect #(.MODE(SYNC_EDGE)) u_sync (
    .clk(clk), .rst(rst), .level(sync_in), .edge_seen(sync_edge)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED:   if (deb_hit) state_d = ST_TRIPPED;
      ST_TRIPPED: if (clr_hit) state_d = ST_REARM;
      ST_REARM:   if (sync_edge) state_d = oc_flag ? ST_TRIPPED : ST_ARMED;
      default:    state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_ARMED;
    else     state_q <= state_d;
  end

  assign fault_pull  = tripped;
  assign pwm_release = tripped;
  assign pwm_pull    = pwm_drive_low && !tripped;

endmodule

// File: rtl/oc_fault_latch_checker.sv
module oc_fault_latch_checker #(
  parameter int DEBOUNCE_CYC = 175,
  parameter int RESET_CYC    = 25
) (
  input logic clk,
  input logic rst,
  input logic oc_flag,
  input logic pwm_line_in,
  input logic fault_pull,
  input logic pwm_release,
  input logic pwm_pull,
  input logic deb_hit,
  input logic clr_hit,
  input logic sync_edge,
  input logic rearm_pending
);

  // Independent run lengths of the raw inputs (samples before this edge).
  int unsigned flag_run, low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_run <= 0;
      low_run  <= 0;
    end else begin
      flag_run <= oc_flag ? ((flag_run < 32'hFFFF) ? flag_run + 1 : flag_run) : 0;
      low_run  <= !pwm_line_in ? ((low_run < 32'hFFFF) ? low_run + 1 : low_run) : 0;
    end
  end

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!fault_pull && !pwm_release));

  // R2
  p_debounce_len_r2: assert property (@(posedge clk) disable iff (rst)
    deb_hit |-> (oc_flag && flag_run >= DEBOUNCE_CYC - 1));

  // R2 / R6
  p_trip_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_pull) |-> ($past(deb_hit) || ($past(rearm_pending) && $past(sync_edge))));

  // R3
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (fault_pull && !clr_hit) |=> fault_pull);

  // R4
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    fault_pull |-> (pwm_release && !pwm_pull));

  // R5
  p_clear_len_r5: assert property (@(posedge clk) disable iff (rst)
    clr_hit |-> (!pwm_line_in && low_run >= RESET_CYC - 1));

  // R6
  p_rearm_trip_r6: assert property (@(posedge clk) disable iff (rst)
    (rearm_pending && sync_edge && oc_flag) |=> fault_pull);

  // R6
  p_rearm_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (rearm_pending && !sync_edge) |=> !fault_pull);

endmodule

bind oc_fault_latch oc_fault_latch_checker #(
  .DEBOUNCE_CYC(DEBOUNCE_CYC),
  .RESET_CYC(RESET_CYC)
) u_chk (.*);

// File: tb/oc_fault_latch_bench.sv
module oc_fault_latch_bench;
  localparam int DEB = 12;
  localparam int RCY = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oc_flag = 1'b0;
  logic sync_in = 1'b0;
  logic ext_line = 1'b1;
  logic pwm_drive_low = 1'b0;
  logic tie = 1'b0;
  logic fault_pull, pwm_release, pwm_pull;
  wire  pwm_line_in = tie ? !(fault_pull || pwm_pull) : (ext_line && !pwm_pull);

  oc_fault_latch #(.DEBOUNCE_CYC(DEB), .RESET_CYC(RCY)) u_oc_fault_latch (
    .clk(clk), .rst(rst), .oc_flag(oc_flag), .sync_in(sync_in),
    .pwm_line_in(pwm_line_in), .pwm_drive_low(pwm_drive_low),
    .fault_pull(fault_pull), .pwm_release(pwm_release), .pwm_pull(pwm_pull)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model: 0 = watching, 1 = tripped, 2 = waiting for SYNC.
  int   m_mode = 0;
  int   m_hi = 0;
  int   m_lo = 0;
  logic m_prev_sync = 1'b0;

  function automatic logic want_fault(input int mode);
    return mode == 1;
  endfunction

  function automatic logic want_pull(input int mode, input logic drv);
    return (mode != 1) && drv;
  endfunction

  function automatic logic model_line(input int mode, input logic drv,
                                      input logic t, input logic ext);
    logic own;
    own = want_pull(mode, drv);
    if (t) return !(want_fault(mode) || own);
    return ext && !own;
  endfunction

  always @(posedge clk) begin
    logic ln, sedge;
    if (rst) begin
      m_mode = 0; m_hi = 0; m_lo = 0; m_prev_sync = 1'b0;   // R1
    end else begin
      ln    = model_line(m_mode, pwm_drive_low, tie, ext_line);
      sedge = (sync_in != m_prev_sync);
      m_prev_sync = sync_in;
      if (m_mode == 0) begin                                 // R2
        m_hi = oc_flag ? m_hi + 1 : 0;
        if (m_hi == DEB) begin m_mode = 1; m_hi = 0; end
      end else if (m_mode == 1) begin                        // R5
        m_lo = !ln ? m_lo + 1 : 0;
        if (m_lo == RCY) begin m_mode = 2; m_lo = 0; end
      end else if (sedge) begin                              // R6
        m_mode = oc_flag ? 1 : 0;
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk("R3 fault_pull vs model", fault_pull, want_fault(m_mode));
    chk("R4 pwm_release vs model", pwm_release, want_fault(m_mode));
    chk("R7 pwm_pull vs model", pwm_pull, want_pull(m_mode, pwm_drive_low));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20250611));
    ticks(2);
    chk("R1 reset fault_pull", fault_pull, 1'b0);
    chk("R1 reset pwm_release", pwm_release, 1'b0);
    rst = 1'b0;

    // R2: a short run is discarded, then the exact length trips.
    oc_flag = 1'b1; ticks(DEB - 1);
    oc_flag = 1'b0; tick();
    chk("R2 broken run", fault_pull, 1'b0);
    oc_flag = 1'b1; ticks(DEB - 1);
    chk("R2 one short", fault_pull, 1'b0);
    tick();
    chk("R2 exact length", fault_pull, 1'b1);

    // R3: flag drop does not clear.
    oc_flag = 1'b0; ticks(10);
    chk("R3 held", fault_pull, 1'b1);

    // R4: own drive request is masked while tripped.
    pwm_drive_low = 1'b1; tick();
    chk("R4 pull masked", pwm_pull, 1'b0);
    chk("R4 released", pwm_release, 1'b1);

    // R5: broken hold is discarded, full hold clears.
    ext_line = 1'b0; ticks(RCY - 1);
    ext_line = 1'b1; tick();
    chk("R5 broken hold", fault_pull, 1'b1);
    ext_line = 1'b0; ticks(RCY - 1);
    chk("R5 one short", fault_pull, 1'b1);
    tick();
    chk("R5 exact hold", fault_pull, 1'b0);
    chk("R7 pull follows request", pwm_pull, 1'b1);
    ext_line = 1'b1; pwm_drive_low = 1'b0;

    // R6: persistent flag waits for a SYNC edge, then trips at once.
    oc_flag = 1'b1; ticks(3 * DEB);
    chk("R6 waits for sync", fault_pull, 1'b0);
    sync_in = 1'b1; tick();
    chk("R6 trips on sync edge", fault_pull, 1'b1);

    // R6: flag gone at the edge returns to armed with a fresh window.
    ext_line = 1'b0; ticks(RCY);
    ext_line = 1'b1; oc_flag = 1'b0;
    sync_in = 1'b0; tick();
    chk("R6 back to armed", fault_pull, 1'b0);
    oc_flag = 1'b1; ticks(DEB - 1);
    chk("R6 fresh window short", fault_pull, 1'b0);
    tick();
    chk("R6 fresh window trips", fault_pull, 1'b1);

    // R1: reset mid-qualification restarts the count.
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset clears trip", fault_pull, 1'b0);
    ticks(DEB / 2);
    rst = 1'b1; tick(); rst = 1'b0;
    ticks(DEB - 1);
    chk("R1 count cleared", fault_pull, 1'b0);
    tick();
    chk("R1 full window after reset", fault_pull, 1'b1);

    // R8: tied pins give fixed-length trips and re-trip on SYNC.
    tie = 1'b1;
    for (int k = 0; k < 3; k++) begin
      n = 0;
      while (fault_pull && n < 100) begin tick(); n++; end
      chk("R8 trip length", (n == RCY), 1'b1);
      sync_in = ~sync_in; tick();
      chk("R8 re-trip on sync", fault_pull, 1'b1);
    end
    tie = 1'b0; oc_flag = 1'b0;

    // Randomized mix against the model.
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 5) == 0) sync_in = ~sync_in;
      if ($urandom_range(0, 15) == 0) oc_flag = ~oc_flag;
      if ($urandom_range(0, 7) == 0) ext_line = ~ext_line;
      pwm_drive_low = ($urandom_range(0, 3) == 0);
      if ((c % 400) == 0) tie = $urandom_range(0, 1) == 1;
      rst = ($urandom_range(0, 699) == 0);
      tick();
    end
    rst = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule